// File: doc/BRIEF.md
# Four-Channel Fly-By DMA Controller

This block moves words between I/O devices and memory without ever holding the data itself. Software gives each of four channels three settings: a start address, a word count and a direction. A device then asks for service by raising its request line. The controller asks the processor for the bus and waits for the grant. It then acknowledges the device and, for each word, drives the memory address and fires one memory strobe together with one I/O strobe. The word passes straight from one side of the bus to the other.

Each transfer runs as a single burst, one word per clock, until the channel's count runs out. The controller then gives the bus back and sets a terminal-count flag for that channel. The interrupt output stays high while any flag is set. Reading status clears all flags. Only one channel is served at a time, and channel 0 has the highest priority.

Top module: `fly_dma`

## Requirements
- R1: After reset, hrq, every dack bit, all four strobes, addr, irq and tc_status are 0. All address, count and direction registers are 0.
- R2: A write with cfg_we high while hrq is low loads one register of channel cfg_ch. The register is picked by cfg_sel: 0 is the address, 1 is the count, 2 is the direction (bit 0 of cfg_wdata), and 3 does nothing. Writes made while hrq is high are ignored.
- R3: While idle, a channel whose dreq is high and whose count is nonzero is selected at a clock edge, and hrq goes high in the next cycle. A channel with a count of 0 is ignored, and hrq stays low.
- R4: While hrq is high and hlda has not yet been seen high at a clock edge, no dack bit and no strobe is asserted.
- R5: The edge that sees hlda high starts exactly one cycle in which dack of the selected channel is high and no strobe is active. Word cycles follow directly after it.
- R6: In each word cycle, direction 0 (memory to device) asserts mem_rd together with io_wr, and direction 1 (device to memory) asserts io_rd together with mem_wr. No other strobe is active.
- R7: The number of word cycles equals the programmed count. addr starts at the programmed address and rises by 1 per word, wrapping from all ones to 0. Afterwards the channel's address register holds the next address and its count is 0. addr is 0 outside word cycles.
- R8: In the cycle after the last word, hrq and dack are low, the channel's tc_status bit is set, and irq is high.
- R9: A cycle with sts_rd high clears every tc_status bit at the next edge. A flag being set at that same edge stays set. irq is high exactly when some tc_status bit is set.
- R10: When several requests are eligible, the lowest-numbered channel is served first. At most one dack bit is ever high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_ch | input | 2 | Channel being written |
| cfg_sel | input | 2 | Register select: 0 address, 1 count, 2 direction |
| cfg_wdata | input | 16 | Write data |
| sts_rd | input | 1 | Status read; clears terminal-count flags |
| dreq | input | 4 | Per-channel device request |
| dack | output | 4 | Per-channel device acknowledge |
| hrq | output | 1 | Bus hold request to the processor |
| hlda | input | 1 | Hold acknowledge from the processor |
| addr | output | 16 | Memory address during word cycles |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| io_rd | output | 1 | I/O read strobe |
| io_wr | output | 1 | I/O write strobe |
| irq | output | 1 | Completion interrupt |
| tc_status | output | 4 | Per-channel terminal-count flags |

## Verification
The assertions check, on every cycle, the rules that need no knowledge of the programmed values. At most one dack is high, and dack never appears without hrq. Strobes always come in legal memory/I/O pairs. dack only rises after a grant. addr steps by one between back-to-back words, and the bus is only released with the interrupt raised. The bench's reference model is needed for the rest: the word count, the start address, the wrap at the top of memory, priority among competing requests, requests ignored on channels with a count of 0, writes dropped while busy, and the case where a status read meets a flag being set at the same edge.

// File: rtl/fly_dma.sv
module fly_dma #(
  parameter int NCH = 4,
  parameter int AW  = 16,
  parameter int CW  = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [1:0]     cfg_ch,
  input  logic [1:0]     cfg_sel,
  input  logic [15:0]    cfg_wdata,
  input  logic           sts_rd,
  input  logic [NCH-1:0] dreq,
  output logic [NCH-1:0] dack,
  output logic           hrq,
  input  logic           hlda,
  output logic [AW-1:0]  addr,
  output logic           mem_rd,
  output logic           mem_wr,
  output logic           io_rd,
  output logic           io_wr,
  output logic           irq,
  output logic [NCH-1:0] tc_status
);
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_ACK, S_XFER} st_t;

  st_t              st_q;
  logic [CHW-1:0]   ch_q, win;
  logic [AW-1:0]    adr_q [NCH];
  logic [CW-1:0]    cnt_q [NCH];
  logic [NCH-1:0]   dir_q, tc_q, tc_nxt, elig;
  logic             last, xfer, cfg_ok;

  for (genvar g = 0; g < NCH; g++) begin : g_elig
    assign elig[g] = dreq[g] && (cnt_q[g] != '0);
  end

  always_comb begin
    win = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if (elig[i]) win = CHW'(i);
  end

  assign xfer   = (st_q == S_XFER);
  assign last   = (cnt_q[ch_q] == CW'(1));
  assign cfg_ok = cfg_we && (st_q == S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= S_IDLE;
      ch_q <= '0;
    end else begin
      case (st_q)
        S_IDLE: if (|elig) begin ch_q <= win; st_q <= S_REQ; end
        S_REQ:  if (hlda) st_q <= S_ACK;
        S_ACK:  st_q <= S_XFER;
        S_XFER: if (last) st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NCH; i++) begin
      if (!rst_n) begin
        adr_q[i] <= '0;
        cnt_q[i] <= '0;
        dir_q[i] <= 1'b0;
      end else if (cfg_ok && (int'(cfg_ch) == i)) begin
        case (cfg_sel)
          2'd0: adr_q[i] <= AW'(cfg_wdata);
          2'd1: cnt_q[i] <= CW'(cfg_wdata);
          2'd2: dir_q[i] <= cfg_wdata[0];
          default: ;
        endcase
      end else if (xfer && (int'(ch_q) == i)) begin
        adr_q[i] <= adr_q[i] + AW'(1);
        cnt_q[i] <= cnt_q[i] - CW'(1);
      end
    end
  end

  always_comb begin
    tc_nxt = sts_rd ? '0 : tc_q;
    if (xfer && last) tc_nxt[ch_q] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) tc_q <= '0;
    else        tc_q <= tc_nxt;
  end

  for (genvar g = 0; g < NCH; g++) begin : g_dack
    assign dack[g] = ((st_q == S_ACK) || xfer) && (int'(ch_q) == g);
  end

  assign hrq       = (st_q != S_IDLE);
  assign addr      = xfer ? adr_q[ch_q] : '0;
  assign mem_rd    = xfer && !dir_q[ch_q];
  assign io_wr     = xfer && !dir_q[ch_q];
  assign io_rd     = xfer &&  dir_q[ch_q];
  assign mem_wr    = xfer &&  dir_q[ch_q];
  assign irq       = |tc_q;
  assign tc_status = tc_q;
endmodule

// File: rtl/fly_dma_chk.sv
module fly_dma_chk #(
  parameter int NCH = 4,
  parameter int AW  = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           hrq,
  input logic           hlda,
  input logic [NCH-1:0] dack,
  input logic [AW-1:0]  addr,
  input logic           mem_rd,
  input logic           mem_wr,
  input logic           io_rd,
  input logic           io_wr,
  input logic           irq
);
  // R10
  one_dack_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(dack));

  // R5
  dack_needs_hrq_chk: assert property (@(posedge clk) disable iff (!rst_n) (|dack) |-> hrq);

  // R4
  dack_after_grant_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(|dack) |-> $past(hlda));

  // R6
  strobe_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd == io_wr) && (mem_wr == io_rd) && !(mem_rd && mem_wr) && ((mem_rd || mem_wr) -> (|dack)));

  // R7
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mem_rd || mem_wr) && $past(mem_rd || mem_wr)) |-> (addr == AW'($past(addr) + 1'b1)));

  // R8
  release_irq_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(hrq) |-> irq);
endmodule

bind fly_dma fly_dma_chk #(.NCH(NCH), .AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .hrq(hrq), .hlda(hlda), .dack(dack), .addr(addr),
  .mem_rd(mem_rd), .mem_wr(mem_wr), .io_rd(io_rd), .io_wr(io_wr), .irq(irq)
);

// File: tb/fly_dma_tb_top.sv
module fly_dma_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_ch = '0, cfg_sel = '0;
  logic [15:0] cfg_wdata = '0;
  logic        sts_rd = 1'b0;
  logic [3:0]  dreq = '0;
  logic [3:0]  dack;
  logic        hrq, hlda = 1'b0;
  logic [15:0] addr;
  logic        mem_rd, mem_wr, io_rd, io_wr, irq;
  logic [3:0]  tc_status;

  int n_chk = 0, n_fail = 0;
  bit run = 0;
  int gdly = 1, gcnt = 0;

  always #4 clk = ~clk;

  fly_dma dut_i (.*);

  // reference model
  int m_st, m_ch;
  int m_adr[4], m_cnt[4], m_dir[4];
  bit [3:0] m_tc;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_ch = 0; m_tc = 0;
      for (int i = 0; i < 4; i++) begin m_adr[i] = 0; m_cnt[i] = 0; m_dir[i] = 0; end
    end else begin
      bit [3:0] ntc;
      int pick;
      ntc = sts_rd ? 4'b0 : m_tc;
      case (m_st)
        0: begin
          pick = -1;
          for (int i = 3; i >= 0; i--) if (dreq[i] && m_cnt[i] != 0) pick = i;
          if (cfg_we) begin
            if (cfg_sel == 0) m_adr[cfg_ch] = cfg_wdata;
            else if (cfg_sel == 1) m_cnt[cfg_ch] = cfg_wdata;
            else if (cfg_sel == 2) m_dir[cfg_ch] = cfg_wdata[0];
          end
          if (pick >= 0) begin m_ch = pick; m_st = 1; end
        end
        1: if (hlda) m_st = 2;
        2: m_st = 3;
        default: begin
          m_adr[m_ch] = (m_adr[m_ch] + 1) & 16'hFFFF;
          m_cnt[m_ch] = m_cnt[m_ch] - 1;
          if (m_cnt[m_ch] == 0) begin ntc[m_ch] = 1'b1; m_st = 0; end
        end
      endcase
      m_tc = ntc;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // per-cycle comparison, then processor grant model
  always @(negedge clk) begin
    if (run) begin
      bit x;
      int ed;
      x = (m_st == 3);
      ed = (m_st == 2 || m_st == 3) ? (1 << m_ch) : 0;
      chk(hrq == (m_st != 0), "R3 hrq", hrq, m_st != 0);
      chk(dack == ed, "R10 dack", dack, ed);
      chk(addr == (x ? m_adr[m_ch] : 0), "R7 addr", addr, x ? m_adr[m_ch] : 0);
      chk({mem_rd, io_wr, io_rd, mem_wr} == {x && m_dir[m_ch] == 0, x && m_dir[m_ch] == 0,
          x && m_dir[m_ch] == 1, x && m_dir[m_ch] == 1}, "R6 strobes",
          {mem_rd, io_wr, io_rd, mem_wr}, m_dir[m_ch]);
      chk(tc_status == m_tc, "R9 tc_status", tc_status, m_tc);
      chk(irq == (m_tc != 0), "R8 irq", irq, m_tc != 0);
    end
    if (hrq === 1'b1) begin
      gcnt++;
      hlda = (gcnt >= gdly);
    end else begin
      gcnt = 0;
      hlda = 1'b0;
    end
  end

  task automatic wr(input int c, input int s, input int v);
    @(negedge clk);
    cfg_we = 1; cfg_ch = 2'(c); cfg_sel = 2'(s); cfg_wdata = 16'(v);
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic prog(input int c, input int a, input int n, input int d);
    wr(c, 0, a); wr(c, 1, n); wr(c, 2, d);
  endtask

  task automatic wait_idle();
    int k;
    k = 0;
    @(negedge clk);
    while (hrq && k < 5000) begin @(negedge clk); k++; end
  endtask

  task automatic status_read();
    @(negedge clk); sts_rd = 1;
    @(negedge clk); sts_rd = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk({hrq, dack, addr, mem_rd, mem_wr, io_rd, io_wr, irq, tc_status} == '0, "R1 reset", addr, 0);
    run = 1;

    // R2 R6 R7 R8: memory to device on channel 2
    prog(2, 16'h1000, 3, 0);
    @(negedge clk); dreq[2] = 1;
    wait_idle(); dreq[2] = 0;
    chk(tc_status == 4'b0100 && irq, "R8 flag after burst", tc_status, 4'b0100);
    status_read();
    chk(tc_status == 0 && !irq, "R9 cleared by read", tc_status, 0);

    // R6 device to memory, single word, slow grant (R4)
    gdly = 5;
    prog(1, 16'h0040, 1, 1);
    @(negedge clk); dreq[1] = 1;
    wait_idle(); dreq[1] = 0;
    gdly = 1;
    status_read();

    // R3 zero-count channel ignored
    prog(3, 16'h2000, 0, 0);
    @(negedge clk); dreq[3] = 1;
    repeat (4) @(negedge clk);
    chk(hrq == 0 && dack == 0, "R3 zero count ignored", hrq, 0);
    dreq[3] = 0;

    // R10 priority: channels 0 and 3 together
    prog(0, 16'h0100, 2, 1);
    prog(3, 16'h0300, 2, 0);
    @(negedge clk); dreq[0] = 1; dreq[3] = 1;
    repeat (4) @(negedge clk);
    chk(dack == 4'b0001, "R10 channel 0 first", dack, 4'b0001);
    wait_idle(); dreq[0] = 0;
    wait_idle(); dreq[3] = 0;
    chk(tc_status == 4'b1001, "R8 both flags", tc_status, 4'b1001);
    status_read();

    // R2 write while busy ignored; R7 address wrap
    prog(1, 16'hFFFE, 4, 0);
    @(negedge clk); dreq[1] = 1;
    repeat (4) @(negedge clk);
    cfg_we = 1; cfg_ch = 1; cfg_sel = 0; cfg_wdata = 16'h5555;
    @(negedge clk); cfg_we = 0;
    chk(addr == 16'h0000, "R7 address wrap", addr, 0);
    wait_idle(); dreq[1] = 0;
    // R9 status read held across completion: set wins
    wr(1, 1, 2);
    @(negedge clk); dreq[1] = 1; sts_rd = 1;
    wait_idle(); dreq[1] = 0;
    chk(tc_status == 4'b0010, "R9 set beats clear", tc_status, 4'b0010);
    sts_rd = 0;
    status_read();
    chk(!irq, "R9 irq low after read", irq, 0);

    repeat (4) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule